// File: doc/BRIEF.md
# Fused Tag-Data Burst Lookup Unit

This unit performs the read side of a lookup in a direct-mapped cache held in DRAM. Every cache set is one 72-byte record made of an 8-byte tag word and a 64-byte line. Twenty-eight such records are packed into each 2 KB row, and the last 32 bytes of the row stay unused. Because the set count is not a power of two, the tag word carries the whole 42-bit line address instead of only the upper address bits.

A client hands over a set index and the full line address. The unit works out the row and the 16-byte-aligned column where the record starts. It issues one read command and gathers the five 16-byte beats that come back. Depending on whether the set is even or odd, the tag word sits in the first or the second 8 bytes of the burst. The unit compares the tag word with the request and reports hit or miss, together with the line, the stored dirty flag and the stored tag. On a miss the dirty flag and the stored tag let a later stage schedule a writeback.

Control is a four-state machine: IDLE, ISSUE, GATHER and REPLY. IDLE goes to ISSUE when a request is accepted. ISSUE goes to GATHER when the read command is taken. GATHER goes to REPLY on the fifth beat. REPLY goes back to IDLE when the response is taken.

Top module: `fused_tag_lookup`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_cmd_valid` and `rsp_valid` are 0.
- R2: For set index s, the command carries `mem_cmd_row` = s / 28 and `mem_cmd_col` = floor(72 × (s mod 28) / 16). The column counts 16-byte units within the row, and col + 5 never exceeds 128.
- R3: Each accepted request produces exactly one command. The command keeps its row and column until `mem_cmd_ready` is seen, and `req_ready` stays 0 from acceptance until the response is taken.
- R4: Exactly five beats are gathered, and only while in GATHER. Any `mem_beat_valid` pulse in the other states is ignored.
- R5: Burst byte order: beat k carries burst bytes 16k to 16k+15, and byte j of a beat sits on `mem_beat_data[8j+7:8j]`. For an even set the tag word is burst bytes 0–7 and the line is bytes 8–71.
- R6: For an odd set (bit 0 of the index is 1) the tag word is burst bytes 8–15 and the line is bytes 16–79.
- R7: Tag word fields: bits [41:0] hold the stored line address, bit 42 is valid and bit 43 is dirty. `rsp_hit` is 1 exactly when valid is 1 and bits [41:0] equal `req_line_addr`.
- R8: `rsp_valid` rises in the cycle after the cycle that delivers the fifth beat. It then holds, with all response fields stable, until `rsp_ready` is seen.
- R9: `rsp_dirty` and `rsp_victim_tag` report the stored bit 43 and bits [41:0] on both hit and miss. On a miss `rsp_line` is all zeros.
- R10: Tag-word bits [63:44] have no effect on any response field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Unit can accept a request |
| req_set | input | 20 | Set index |
| req_line_addr | input | 42 | Full line address to match |
| mem_cmd_valid | output | 1 | Read burst command present |
| mem_cmd_ready | input | 1 | DRAM side takes the command |
| mem_cmd_row | output | 20 | Row holding the record |
| mem_cmd_col | output | 7 | Starting column in 16-byte units |
| mem_beat_valid | input | 1 | A read beat is on the bus |
| mem_beat_data | input | 128 | Read beat data |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_hit | output | 1 | Lookup hit |
| rsp_dirty | output | 1 | Stored dirty bit |
| rsp_victim_tag | output | 42 | Stored line address |
| rsp_line | output | 512 | Fetched line on hit, zero on miss |

## Verification
Sets are tried at both parities and at the slot edges of a row (0, 1, 27, 28, 55), so that a wrong parity split or a wrong row/column division shows up in the command or in misplaced line bytes. The tag words are chosen to give a hit, a miss on the address, a miss on a cleared valid bit with a matching address, and a dirty miss. These cases separate the compare from the valid gating and check that the victim fields are still reported. Random filler in the ignored bytes and in the spare tag bits exposes any use of those bytes. Stray beats sent before the command is taken and while the result is held show whether the beat counter is gated by state. Random command and response stalls check that the command and the result stay stable.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_GATHER,
        ST_REPLY
    } ftl_state_e;

    localparam int TAG_BITS  = 42;
    localparam int VALID_POS = 42;
    localparam int DIRTY_POS = 43;

endpackage

// File: rtl/ftl_slot_map.sv
module ftl_slot_map #(
    parameter int SET_W        = 20,
    parameter int ROW_W        = 20,
    parameter int COL_W        = 7,
    parameter int RECS_PER_ROW = 28,
    parameter int REC_BYTES    = 72,
    parameter int BUS_BYTES    = 16,
    parameter int ROW_BYTES    = 2048
) (
    input  logic [SET_W-1:0] set_idx,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col,
    output logic             odd_set
);
    localparam int SLOT_W = $clog2(RECS_PER_ROW);
    localparam int BYTE_W = $clog2(ROW_BYTES);
    localparam int BUS_SH = $clog2(BUS_BYTES);
    localparam logic [SET_W-1:0] RECS = SET_W'(RECS_PER_ROW);

    logic [SET_W-1:0]  quot;
    logic [SET_W-1:0]  rem;
    logic [SLOT_W-1:0] slot;
    logic [BYTE_W-1:0] byte_off;

    always_comb begin
        quot     = set_idx / RECS;
        rem      = set_idx % RECS;
        slot     = SLOT_W'(rem);
        byte_off = BYTE_W'(slot) * BYTE_W'(REC_BYTES);
        row      = ROW_W'(quot);
        col      = byte_off[BYTE_W-1:BUS_SH];
        odd_set  = set_idx[0];
    end

endmodule

// File: rtl/ftl_beat_gather.sv
module ftl_beat_gather #(
    parameter int BUS_W = 128,
    parameter int BEATS = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   beat_en,
    input  logic [BUS_W-1:0]       beat_data,
    output logic [BEATS*BUS_W-1:0] burst,
    output logic                   last
);
    localparam int CNT_W = $clog2(BEATS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [BUS_W-1:0] slot_q [BEATS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (beat_en) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (beat_en && cnt_q == CNT_W'(g)) begin
                slot_q[g] <= beat_data;
            end
        end
        assign burst[g*BUS_W +: BUS_W] = slot_q[g];
    end

    assign last = beat_en && (cnt_q == LAST_IDX);

endmodule

// File: rtl/ftl_tag_judge.sv
module ftl_tag_judge
    import ftl_pkg::*;
#(
    parameter int BURST_W = 640,
    parameter int TW_W    = 64,
    parameter int LINE_W  = 512
) (
    input  logic [BURST_W-1:0]  burst,
    input  logic                odd_set,
    input  logic [TAG_BITS-1:0] req_tag,
    output logic                hit,
    output logic                dirty,
    output logic [TAG_BITS-1:0] victim_tag,
    output logic [LINE_W-1:0]   line
);
    logic [TW_W-1:0]   tag_word;
    logic [LINE_W-1:0] raw_line;
    logic              spare_unused;

    always_comb begin
        if (odd_set) begin
            tag_word = burst[TW_W +: TW_W];
            raw_line = burst[2*TW_W +: LINE_W];
        end else begin
            tag_word = burst[0 +: TW_W];
            raw_line = burst[TW_W +: LINE_W];
        end
        victim_tag = tag_word[TAG_BITS-1:0];
        dirty      = tag_word[DIRTY_POS];
        hit        = tag_word[VALID_POS] && (victim_tag == req_tag);
        line       = hit ? raw_line : '0;
    end

    assign spare_unused = ^tag_word[TW_W-1:DIRTY_POS+1];

endmodule

// File: rtl/fused_tag_lookup.sv
module fused_tag_lookup
    import ftl_pkg::*;
#(
    parameter int SET_W      = 20,
    parameter int ROW_BYTES  = 2048,
    parameter int REC_BYTES  = 72,
    parameter int TW_BYTES   = 8,
    parameter int LINE_BYTES = 64,
    parameter int BUS_BYTES  = 16,
    localparam int RECS_PER_ROW = ROW_BYTES / REC_BYTES,
    localparam int BEATS     = (REC_BYTES + TW_BYTES + BUS_BYTES - 1) / BUS_BYTES,
    localparam int BUS_W     = BUS_BYTES * 8,
    localparam int ROW_BEATS = ROW_BYTES / BUS_BYTES,
    localparam int COL_W     = $clog2(ROW_BEATS),
    localparam int ROW_W     = SET_W,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int TW_W      = TW_BYTES * 8,
    localparam int BURST_W   = BEATS * BUS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SET_W-1:0]    req_set,
    input  logic [TAG_BITS-1:0] req_line_addr,
    output logic                mem_cmd_valid,
    input  logic                mem_cmd_ready,
    output logic [ROW_W-1:0]    mem_cmd_row,
    output logic [COL_W-1:0]    mem_cmd_col,
    input  logic                mem_beat_valid,
    input  logic [BUS_W-1:0]    mem_beat_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic                rsp_hit,
    output logic                rsp_dirty,
    output logic [TAG_BITS-1:0] rsp_victim_tag,
    output logic [LINE_W-1:0]   rsp_line
);

    ftl_state_e state_q, state_d;

    logic [SET_W-1:0]    set_q;
    logic [TAG_BITS-1:0] tag_q;
    logic                accept;
    logic                beat_en;
    logic                gather_last;
    logic                odd_set;
    logic [BURST_W-1:0]  burst;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE:  if (mem_cmd_ready) state_d = ST_GATHER;
            ST_GATHER: if (gather_last)   state_d = ST_REPLY;
            ST_REPLY:  if (rsp_ready)     state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_cmd_valid = 1'b0;
        rsp_valid     = 1'b0;
        beat_en       = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready     = 1'b1;
            ST_ISSUE:  mem_cmd_valid = 1'b1;
            ST_GATHER: beat_en       = mem_beat_valid;
            ST_REPLY:  rsp_valid     = 1'b1;
            default:   req_ready     = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= '0;
            tag_q <= '0;
        end else if (accept) begin
            set_q <= req_set;
            tag_q <= req_line_addr;
        end
    end

    ftl_slot_map #(
        .SET_W        (SET_W),
        .ROW_W        (ROW_W),
        .COL_W        (COL_W),
        .RECS_PER_ROW (RECS_PER_ROW),
        .REC_BYTES    (REC_BYTES),
        .BUS_BYTES    (BUS_BYTES),
        .ROW_BYTES    (ROW_BYTES)
    ) u_map (
        .set_idx (set_q),
        .row     (mem_cmd_row),
        .col     (mem_cmd_col),
        .odd_set (odd_set)
    );

    ftl_beat_gather #(
        .BUS_W (BUS_W),
        .BEATS (BEATS)
    ) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .beat_en   (beat_en),
        .beat_data (mem_beat_data),
        .burst     (burst),
        .last      (gather_last)
    );

    ftl_tag_judge #(
        .BURST_W (BURST_W),
        .TW_W    (TW_W),
        .LINE_W  (LINE_W)
    ) u_judge (
        .burst      (burst),
        .odd_set    (odd_set),
        .req_tag    (tag_q),
        .hit        (rsp_hit),
        .dirty      (rsp_dirty),
        .victim_tag (rsp_victim_tag),
        .line       (rsp_line)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !mem_cmd_valid && !rsp_valid)); // R1

    AST_COL_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cmd_valid |-> (({1'b0, mem_cmd_col} + (COL_W+1)'(BEATS)) <= (COL_W+1)'(ROW_BEATS))); // R2

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd_valid && !mem_cmd_ready) |=>
            (mem_cmd_valid && $stable(mem_cmd_row) && $stable(mem_cmd_col))); // R3

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R3

    AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        gather_last |=> rsp_valid); // R8

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_hit) && $stable(rsp_dirty) &&
             $stable(rsp_victim_tag) && $stable(rsp_line))); // R8

endmodule

// File: tb/fused_tag_lookup_tb_top.sv
module fused_tag_lookup_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [19:0]  req_set = '0;
    logic [41:0]  req_line_addr = '0;
    logic         mem_cmd_valid;
    logic         mem_cmd_ready = 1'b0;
    logic [19:0]  mem_cmd_row;
    logic [6:0]   mem_cmd_col;
    logic         mem_beat_valid = 1'b0;
    logic [127:0] mem_beat_data = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic         rsp_hit;
    logic         rsp_dirty;
    logic [41:0]  rsp_victim_tag;
    logic [511:0] rsp_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fused_tag_lookup dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_set(req_set), .req_line_addr(req_line_addr),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
        .mem_cmd_row(mem_cmd_row), .mem_cmd_col(mem_cmd_col),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_hit(rsp_hit), .rsp_dirty(rsp_dirty),
        .rsp_victim_tag(rsp_victim_tag), .rsp_line(rsp_line)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_row(input logic [19:0] s);
        return s / 20'd28;
    endfunction

    function automatic logic [6:0] exp_col(input logic [19:0] s);
        int slot;
        slot = int'(s % 20'd28);
        return 7'((slot * 72) / 16);
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic run_txn(input logic [19:0] set, input logic [41:0] addr,
                           input logic [63:0] tw, input logic [511:0] line,
                           input int cmd_wait, input int rsp_wait);
        logic [639:0] burst;
        logic [63:0]  fill;
        bit           e_hit;
        logic [511:0] e_line;
        string        preq;
        fill = rnd64();
        if (set[0]) begin
            burst = {line, tw, fill};
            preq  = "R6";
        end else begin
            burst = {fill, line, tw};
            preq  = "R5";
        end
        e_hit  = tw[42] && (tw[41:0] == addr);
        e_line = e_hit ? line : '0;

        @(negedge clk);
        req_valid = 1'b1; req_set = set; req_line_addr = addr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_set = 20'($urandom); req_line_addr = '0;
        chk(req_ready == 1'b0, "R3", "req_ready busy", 512'(req_ready), 512'd0);
        chk(mem_cmd_valid == 1'b1, "R3", "cmd issued", 512'(mem_cmd_valid), 512'd1);
        chk(mem_cmd_row == exp_row(set), "R2", "row", 512'(mem_cmd_row), 512'(exp_row(set)));
        chk(mem_cmd_col == exp_col(set), "R2", "col", 512'(mem_cmd_col), 512'(exp_col(set)));
        // stray beat before the command is taken (R4)
        mem_beat_valid = 1'b1; mem_beat_data = {$urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        mem_beat_valid = 1'b0;
        for (int i = 0; i < cmd_wait; i++) @(negedge clk);
        chk(mem_cmd_valid == 1'b1 && mem_cmd_col == exp_col(set), "R3", "cmd held",
            512'(mem_cmd_col), 512'(exp_col(set)));
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        chk(mem_cmd_valid == 1'b0, "R3", "single cmd", 512'(mem_cmd_valid), 512'd0);

        for (int b = 0; b < 5; b++) begin
            int gap;
            gap = int'($urandom % 3);
            for (int i = 0; i < gap; i++) @(negedge clk);
            if (b == 4)
                chk(rsp_valid == 1'b0, "R8", "no early rsp", 512'(rsp_valid), 512'd0);
            mem_beat_valid = 1'b1; mem_beat_data = burst[b*128 +: 128];
            @(negedge clk);
            mem_beat_valid = 1'b0;
        end
        chk(rsp_valid == 1'b1, "R8", "rsp one cycle after last beat", 512'(rsp_valid), 512'd1);

        for (int i = 0; i < rsp_wait; i++) begin
            if (i == 0) begin
                mem_beat_valid = 1'b1; mem_beat_data = ~burst[127:0];
            end
            @(negedge clk);
            mem_beat_valid = 1'b0;
            chk(rsp_valid == 1'b1 && rsp_line == e_line, "R4", "rsp held, extra beat ignored",
                rsp_line, e_line);
        end

        chk(rsp_hit == e_hit, "R7", "hit", 512'(rsp_hit), 512'(e_hit));
        chk(rsp_dirty == tw[43], "R9", "dirty", 512'(rsp_dirty), 512'(tw[43]));
        chk(rsp_victim_tag == tw[41:0], "R9", "victim tag", 512'(rsp_victim_tag), 512'(tw[41:0]));
        chk(rsp_line == e_line, e_hit ? preq : "R9", "line", rsp_line, e_line);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R3", "back to idle",
            512'({rsp_valid, req_ready}), 512'd1);
    endtask

    function automatic logic [63:0] mk_tw(input logic [19:0] spare, input bit dirty,
                                          input bit valid, input logic [41:0] tag);
        return {spare, dirty, valid, tag};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R8 actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [41:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_cmd_valid == 1'b0 && rsp_valid == 1'b0, "R1",
            "reset state", 512'({req_ready, mem_cmd_valid, rsp_valid}), 512'b100);

        a = 42'h2A5_5A5A_1234;
        // directed: even set 0 hit, clean
        run_txn(20'd0, a, mk_tw(20'h0, 1'b0, 1'b1, a), rnd512(), 0, 0);
        // odd set 1 hit, dirty
        run_txn(20'd1, a, mk_tw(20'h0, 1'b1, 1'b1, a), rnd512(), 2, 1);
        // last slot of row 0, tag mismatch, dirty victim
        run_txn(20'd27, a, mk_tw(20'h0, 1'b1, 1'b1, a ^ 42'h1), rnd512(), 1, 2);
        // first slot of row 1, matching tag but invalid
        run_txn(20'd28, a, mk_tw(20'h0, 1'b0, 1'b0, a), rnd512(), 0, 1);
        // last slot of row 1, spare bits set, hit (R10)
        run_txn(20'd55, a, mk_tw(20'hFFFFF, 1'b0, 1'b1, a), rnd512(), 3, 0);
        // large set index, spare bits set, miss (R10)
        run_txn(20'hFFFFF, a, mk_tw(20'hA5A5A, 1'b1, 1'b1, ~a), rnd512(), 1, 3);

        for (int n = 0; n < 60; n++) begin
            logic [19:0] s;
            logic [41:0] ad;
            logic [41:0] t;
            s  = 20'($urandom);
            ad = 42'({$urandom, $urandom});
            t  = ($urandom % 2 == 0) ? ad : 42'({$urandom, $urandom});
            run_txn(s, ad, mk_tw(20'($urandom), 1'($urandom), 1'($urandom), t), rnd512(),
                    int'($urandom % 4), int'($urandom % 4));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule